// File: doc/BRIEF.md
# Ring Stop with Miss-Bypass Filter

This block is one stop on a one-way ring that links cache controllers. A slot register holds the request that leaves this stop, and it is reloaded on every clock. Each cycle the stop looks at the incoming slot and takes one of three actions. A request that started at this stop and has gone round the ring is retired. A request that started elsewhere is passed on. A free slot is filled with the oldest request from a short local queue. Traffic already on the ring always takes the outgoing slot before local traffic does.

Requests from other stops normally query the local cache through a simple lookup port. A small fully associative filter remembers the addresses that recently missed in that cache. A request from another stop whose address is in the filter goes straight to the next stop without a lookup. When a local request for an address is accepted, that address is removed from the filter, because the local access may bring the line into the cache.

Top module: `ringstop_node`

## Requirements
- R1: While reset is held and on the first cycle after it, `ring_out_valid` and `ret_valid` are 0, `lreq_ready` is 1, and the miss filter holds no address.
- R2: A valid incoming slot whose origin differs from `NODE_ID` appears on the `ring_out_*` ports one cycle later with origin, type and address unchanged.
- R3: A valid incoming slot whose origin equals `NODE_ID` is not passed on. One cycle later `ret_valid` is 1, with the slot's type and address on `ret_type` and `ret_addr`.
- R4: A local request is placed in the outgoing slot only in a cycle whose incoming slot is empty or is being retired. The placed slot carries origin `NODE_ID`, and local requests leave in the order they were accepted.
- R5: The local queue holds 4 requests. `lreq_ready` is 0 exactly while 4 are held, and a request is accepted in a cycle where `lreq_valid` and `lreq_ready` are both 1.
- R6: A request from another stop whose address is not in the filter raises `lk_valid` in the same cycle, with its address on `lk_addr`. If `lk_hit` is 0 in that cycle, the address is added to the filter.
- R7: A request from another stop whose address is in the filter leaves `lk_valid` at 0 in that cycle and is still passed on as in R2.
- R8: An accepted local request removes its address from the filter. If a miss on the same address would be recorded in the same cycle, it is not recorded.
- R9: The filter holds 4 addresses with first-in first-out replacement. Recording a fifth distinct address drops the oldest one.
- R10: A lookup that returns `lk_hit` = 1 does not add the address to the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_in_valid | input | 1 | Incoming slot holds a request |
| ring_in_origin | input | ID_W | Stop that issued the incoming request |
| ring_in_type | input | TYPE_W | Request type of the incoming request |
| ring_in_addr | input | ADDR_W | Address of the incoming request |
| lreq_valid | input | 1 | Local request offered |
| lreq_type | input | TYPE_W | Local request type |
| lreq_addr | input | ADDR_W | Local request address |
| lreq_ready | output | 1 | Local queue can accept a request |
| lk_valid | output | 1 | Cache lookup strobe, combinational |
| lk_addr | output | ADDR_W | Cache lookup address |
| lk_hit | input | 1 | Cache lookup result, same cycle |
| ring_out_valid | output | 1 | Outgoing slot holds a request |
| ring_out_origin | output | ID_W | Origin of the outgoing request |
| ring_out_type | output | TYPE_W | Type of the outgoing request |
| ring_out_addr | output | ADDR_W | Address of the outgoing request |
| ret_valid | output | 1 | A request of this stop came back last cycle |
| ret_type | output | TYPE_W | Type of the retired request |
| ret_addr | output | ADDR_W | Address of the retired request |

## Verification
The lookup strobe and `lreq_ready` are combinational. They are sampled one time step after inputs are driven, within the cycle of the stimulus. The outgoing slot and the retire outputs go through one register, so they are compared at the next falling edge against the reference state updated for that stimulus. A change to the filter shows up one cycle later, as the presence or absence of a lookup for a repeated address. The directed sequences place such repeats right after the miss, the eviction or the local clear under test.

// File: rtl/ringstop_pkg.sv
// Package: shared types for the ring stop.
// Assumes: nothing beyond IEEE 1800-2017.
package ringstop_pkg;

    // Source selected for the outgoing ring slot in a cycle.
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_FORWARD = 2'd1,
        SRC_LOCAL   = 2'd2
    } slot_src_e;

endpackage

// File: rtl/rs_local_fifo.sv
// Module: in-order queue for local requests waiting for a free ring slot.
// Assumes: the caller never pushes while full or pops while empty.
module rs_local_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    // Status seen by the producer and the arbiter.
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rs_miss_filter.sv
// Module: small fully associative store of addresses known to miss locally.
// A probe reports a match in the same cycle. Insertions replace the entries
// in FIFO order. A clear drops every entry that matches its address, but an
// insertion into the same entry in that cycle takes precedence.
// Assumes: DEPTH >= 2; the caller never inserts an address already held.
module rs_miss_filter #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0]  ent_valid;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DEPTH-1:0]  probe_match;
    logic [PTR_W-1:0]  rep_ptr;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Match the probe address against this entry.
        assign probe_match[i] = ent_valid[i] && (ent_addr[i] == probe_addr);

        // Entry update: insertion first, then clear on a local access.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
                ent_addr[i]  <= '0;
            end else if (ins_en && (rep_ptr == PTR_W'(i))) begin
                ent_valid[i] <= 1'b1;
                ent_addr[i]  <= ins_addr;
            end else if (clr_en && ent_valid[i] && (ent_addr[i] == clr_addr)) begin
                ent_valid[i] <= 1'b0;
            end
        end
    end

    // Any entry matching counts as a hit.
    assign probe_hit = |probe_match;

    // Replacement pointer moves on every insertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_ptr <= '0;
        end else if (ins_en) begin
            rep_ptr <= (rep_ptr == LAST) ? '0 : rep_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/rs_slot_arbiter.sv
// Module: decides the next content of the outgoing ring slot and registers it.
// Ring traffic from other stops wins. A returning request of this stop is
// retired, which frees the slot for the local queue head.
// Assumes: q_type/q_addr are valid whenever q_empty is 0.
module rs_slot_arbiter
    import ringstop_pkg::*;
#(
    parameter int ID_W    = 3,
    parameter int TYPE_W  = 2,
    parameter int ADDR_W  = 8,
    parameter int NODE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ID_W-1:0]   in_origin,
    input  logic [TYPE_W-1:0] in_type,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              q_empty,
    input  logic [TYPE_W-1:0] q_type,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              in_own,
    output logic              q_pop,
    output logic              out_valid,
    output logic [ID_W-1:0]   out_origin,
    output logic [TYPE_W-1:0] out_type,
    output logic [ADDR_W-1:0] out_addr,
    output logic              ret_valid,
    output logic [TYPE_W-1:0] ret_type,
    output logic [ADDR_W-1:0] ret_addr
);
    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    slot_src_e src;

    // Select the slot source: ring first, then the local queue.
    always_comb begin
        in_own = in_valid && (in_origin == MY_ID);
        if (in_valid && !in_own) begin
            src = SRC_FORWARD;
        end else if (!q_empty) begin
            src = SRC_LOCAL;
        end else begin
            src = SRC_NONE;
        end
        q_pop = (src == SRC_LOCAL);
    end

    // Outgoing slot register, reloaded every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_origin <= '0;
            out_type   <= '0;
            out_addr   <= '0;
        end else begin
            case (src)
                SRC_FORWARD: begin
                    out_valid  <= 1'b1;
                    out_origin <= in_origin;
                    out_type   <= in_type;
                    out_addr   <= in_addr;
                end
                SRC_LOCAL: begin
                    out_valid  <= 1'b1;
                    out_origin <= MY_ID;
                    out_type   <= q_type;
                    out_addr   <= q_addr;
                end
                default: begin
                    out_valid  <= 1'b0;
                end
            endcase
        end
    end

    // Retire register for requests that came back to this stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid <= 1'b0;
            ret_type  <= '0;
            ret_addr  <= '0;
        end else begin
            ret_valid <= in_own;
            if (in_own) begin
                ret_type <= in_type;
                ret_addr <= in_addr;
            end
        end
    end

endmodule

// File: rtl/ringstop_node.sv
// Module: one stop of a one-way request ring between cache controllers.
// Joins the slot arbiter, the local request queue and the miss filter, and
// drives the cache lookup port for requests from other stops that are not
// known to miss.
// Assumes: lk_hit is a same-cycle answer to lk_addr while lk_valid is 1.
module ringstop_node #(
    parameter int ID_W     = 3,
    parameter int TYPE_W   = 2,
    parameter int ADDR_W   = 8,
    parameter int NODE_ID  = 2,
    parameter int LQ_DEPTH = 4,
    parameter int MF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_in_valid,
    input  logic [ID_W-1:0]   ring_in_origin,
    input  logic [TYPE_W-1:0] ring_in_type,
    input  logic [ADDR_W-1:0] ring_in_addr,
    input  logic              lreq_valid,
    input  logic [TYPE_W-1:0] lreq_type,
    input  logic [ADDR_W-1:0] lreq_addr,
    output logic              lreq_ready,
    output logic              lk_valid,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_hit,
    output logic              ring_out_valid,
    output logic [ID_W-1:0]   ring_out_origin,
    output logic [TYPE_W-1:0] ring_out_type,
    output logic [ADDR_W-1:0] ring_out_addr,
    output logic              ret_valid,
    output logic [TYPE_W-1:0] ret_type,
    output logic [ADDR_W-1:0] ret_addr
);
    localparam int ENTRY_W = TYPE_W + ADDR_W;

    logic               q_full;
    logic               q_empty;
    logic               q_pop;
    logic               q_push;
    logic [ENTRY_W-1:0] q_head;
    logic               in_own;
    logic               mf_hit;
    logic               mf_ins;

    // Handshake, lookup strobe and filter insertion decisions.
    always_comb begin
        lreq_ready = !q_full;
        q_push     = lreq_valid && !q_full;
        lk_valid   = ring_in_valid && !in_own && !mf_hit;
        lk_addr    = ring_in_addr;
        mf_ins     = lk_valid && !lk_hit && !(q_push && (lreq_addr == ring_in_addr));
    end

    rs_local_fifo #(
        .W     (ENTRY_W),
        .DEPTH (LQ_DEPTH)
    ) u_lq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data ({lreq_type, lreq_addr}),
        .pop       (q_pop),
        .head      (q_head),
        .full      (q_full),
        .empty     (q_empty)
    );

    rs_miss_filter #(
        .ADDR_W (ADDR_W),
        .DEPTH  (MF_DEPTH)
    ) u_mf (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_addr (ring_in_addr),
        .probe_hit  (mf_hit),
        .ins_en     (mf_ins),
        .ins_addr   (ring_in_addr),
        .clr_en     (q_push),
        .clr_addr   (lreq_addr)
    );

    rs_slot_arbiter #(
        .ID_W    (ID_W),
        .TYPE_W  (TYPE_W),
        .ADDR_W  (ADDR_W),
        .NODE_ID (NODE_ID)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (ring_in_valid),
        .in_origin  (ring_in_origin),
        .in_type    (ring_in_type),
        .in_addr    (ring_in_addr),
        .q_empty    (q_empty),
        .q_type     (q_head[ENTRY_W-1:ADDR_W]),
        .q_addr     (q_head[ADDR_W-1:0]),
        .in_own     (in_own),
        .q_pop      (q_pop),
        .out_valid  (ring_out_valid),
        .out_origin (ring_out_origin),
        .out_type   (ring_out_type),
        .out_addr   (ring_out_addr),
        .ret_valid  (ret_valid),
        .ret_type   (ret_type),
        .ret_addr   (ret_addr)
    );

endmodule

// File: rtl/ringstop_node_chk.sv
// Module: property checker for the ring stop, attached by bind.
// Assumes: it sees the top-level ports only.
module ringstop_node_chk #(
    parameter int ID_W    = 3,
    parameter int ADDR_W  = 8,
    parameter int NODE_ID = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_in_valid,
    input logic [ID_W-1:0]   ring_in_origin,
    input logic [ADDR_W-1:0] ring_in_addr,
    input logic              lreq_valid,
    input logic [ADDR_W-1:0] lreq_addr,
    input logic              lreq_ready,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_hit,
    input logic              ring_out_valid,
    input logic [ID_W-1:0]   ring_out_origin,
    input logic [ADDR_W-1:0] ring_out_addr,
    input logic              ret_valid,
    input logic [ADDR_W-1:0] ret_addr
);
    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    // R2: foreign traffic reappears one cycle later, unchanged.
    p_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_in_valid && ring_in_origin != MY_ID) |=>
        (ring_out_valid && ring_out_origin == $past(ring_in_origin)
         && ring_out_addr == $past(ring_in_addr)));

    // R3: a returning request of this stop is retired next cycle.
    p_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_in_valid && ring_in_origin == MY_ID) |=>
        (ret_valid && ret_addr == $past(ring_in_addr)));

    // R4: an idle slot with a full local queue gets a local request.
    p_inject_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_in_valid && !lreq_ready) |=>
        (ring_out_valid && ring_out_origin == MY_ID));

    // R7: lookups only for requests from other stops.
    p_lookup_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (ring_in_valid && ring_in_origin != MY_ID));

    // R6: a recorded miss makes the next request to it skip the lookup.
    p_skip_after_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit && !(lreq_valid && lreq_ready && lreq_addr == lk_addr))
        ##1 (ring_in_valid && ring_in_origin != MY_ID && ring_in_addr == $past(lk_addr))
        |-> !lk_valid);

endmodule

bind ringstop_node ringstop_node_chk #(
    .ID_W    (ID_W),
    .ADDR_W  (ADDR_W),
    .NODE_ID (NODE_ID)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ring_in_valid   (ring_in_valid),
    .ring_in_origin  (ring_in_origin),
    .ring_in_addr    (ring_in_addr),
    .lreq_valid      (lreq_valid),
    .lreq_addr       (lreq_addr),
    .lreq_ready      (lreq_ready),
    .lk_valid        (lk_valid),
    .lk_addr         (lk_addr),
    .lk_hit          (lk_hit),
    .ring_out_valid  (ring_out_valid),
    .ring_out_origin (ring_out_origin),
    .ring_out_addr   (ring_out_addr),
    .ret_valid       (ret_valid),
    .ret_addr        (ret_addr)
);

// File: tb/sim_ringstop_node.sv
`timescale 1ns/1ps
module sim_ringstop_node;
    localparam int ME = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ring_in_valid = 1'b0;
    logic [2:0] ring_in_origin = '0;
    logic [1:0] ring_in_type = '0;
    logic [7:0] ring_in_addr = '0;
    logic       lreq_valid = 1'b0;
    logic [1:0] lreq_type = '0;
    logic [7:0] lreq_addr = '0;
    logic       lreq_ready;
    logic       lk_valid;
    logic [7:0] lk_addr;
    logic       lk_hit;
    logic       ring_out_valid;
    logic [2:0] ring_out_origin;
    logic [1:0] ring_out_type;
    logic [7:0] ring_out_addr;
    logic       ret_valid;
    logic [1:0] ret_type;
    logic [7:0] ret_addr;

    int vectors = 0;
    int errors = 0;
    bit done = 0;

    // Cache model: addresses ending in binary 11 hit.
    assign lk_hit = lk_valid && (lk_addr[1:0] == 2'b11);

    always #2.5 clk = ~clk;

    ringstop_node #(.NODE_ID(ME)) u0 (.*);

    // Reference model state.
    logic [1:0] mq_t[$];
    logic [7:0] mq_a[$];
    bit         mf_v[4];
    logic [7:0] mf_a[4];
    int         mf_p = 0;
    bit         e_ov = 0, e_rv = 0;
    logic [2:0] e_oo; logic [1:0] e_ot; logic [7:0] e_oa;
    logic [1:0] e_rt; logic [7:0] e_ra;
    string      e_otag = "R2";

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic check_regs();
        chk(ring_out_valid == e_ov, {e_otag, " ring_out_valid"}, ring_out_valid, e_ov);
        if (e_ov) begin
            chk(ring_out_origin == e_oo, {e_otag, " ring_out_origin"}, ring_out_origin, e_oo);
            chk(ring_out_type == e_ot, {e_otag, " ring_out_type"}, ring_out_type, e_ot);
            chk(ring_out_addr == e_oa, {e_otag, " ring_out_addr"}, ring_out_addr, e_oa);
        end
        chk(ret_valid == e_rv, "R3 ret_valid", ret_valid, e_rv);
        if (e_rv) begin
            chk(ret_type == e_rt, "R3 ret_type", ret_type, e_rt);
            chk(ret_addr == e_ra, "R3 ret_addr", ret_addr, e_ra);
        end
    endtask

    // One cycle: drive, check combinational outputs, advance model, check registers.
    task automatic cyc(input bit iv, input int io, input int it, input int ia,
                       input bit lv, input int lt, input int la, input string tag);
        bit own, bhit, exp_lk, ready, acc, ins;
        ring_in_valid = iv; ring_in_origin = 3'(io); ring_in_type = 2'(it);
        ring_in_addr = 8'(ia); lreq_valid = lv; lreq_type = 2'(lt); lreq_addr = 8'(la);
        #1;
        own = iv && (io == ME);
        bhit = 0;
        for (int i = 0; i < 4; i++) if (mf_v[i] && mf_a[i] == 8'(ia)) bhit = 1;
        exp_lk = iv && !own && !bhit;
        ready = (mq_a.size() < 4);
        acc = lv && ready;
        chk(lk_valid == exp_lk, (tag != "") ? {tag, " lk_valid"} : (bhit ? "R7 lk_valid" : "R6 lk_valid"),
            lk_valid, exp_lk);
        if (exp_lk) chk(lk_addr == 8'(ia), "R6 lk_addr", lk_addr, ia);
        chk(lreq_ready == ready, "R5 lreq_ready", lreq_ready, ready);
        // Filter update: insertion into the pointed entry wins over a clear.
        ins = exp_lk && (8'(ia) & 8'h3) != 8'h3 && !(acc && 8'(la) == 8'(ia));
        for (int i = 0; i < 4; i++) begin
            if (ins && mf_p == i) begin mf_v[i] = 1; mf_a[i] = 8'(ia); end
            else if (acc && mf_v[i] && mf_a[i] == 8'(la)) mf_v[i] = 0;
        end
        if (ins) mf_p = (mf_p + 1) % 4;
        // Slot and retire expectations.
        e_rv = own; if (own) begin e_rt = 2'(it); e_ra = 8'(ia); end
        if (iv && !own) begin
            e_ov = 1; e_oo = 3'(io); e_ot = 2'(it); e_oa = 8'(ia); e_otag = "R2";
        end else if (mq_a.size() > 0) begin
            e_ov = 1; e_oo = 3'(ME); e_ot = mq_t.pop_front(); e_oa = mq_a.pop_front(); e_otag = "R4";
        end else begin
            e_ov = 0; e_otag = "R4";
        end
        if (acc) begin mq_t.push_back(2'(lt)); mq_a.push_back(8'(la)); end
        @(negedge clk);
        check_regs();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin mf_v[i] = 0; mf_a[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(ring_out_valid == 0, "R1 ring_out_valid", ring_out_valid, 0);
        chk(ret_valid == 0, "R1 ret_valid", ret_valid, 0);
        chk(lreq_ready == 1, "R1 lreq_ready", lreq_ready, 1);
        rst_n = 1'b1;
        // R1: empty filter, so the first foreign request is looked up.
        cyc(1, 5, 1, 8'h10, 0, 0, 0, "R1");
        // R9: fill the filter, confirm a hit, then evict the oldest.
        cyc(1, 5, 0, 8'h20, 0, 0, 0, "");
        cyc(1, 6, 0, 8'h30, 0, 0, 0, "");
        cyc(1, 7, 0, 8'h40, 0, 0, 0, "");
        cyc(1, 4, 2, 8'h10, 0, 0, 0, "R7");
        cyc(1, 4, 0, 8'h50, 0, 0, 0, "");
        cyc(1, 4, 0, 8'h10, 0, 0, 0, "R9");
        // R10: a lookup hit is not recorded.
        cyc(1, 1, 0, 8'h13, 0, 0, 0, "");
        cyc(1, 1, 0, 8'h13, 0, 0, 0, "R10");
        // R8: a local access clears its entry (0x40 is held).
        cyc(0, 0, 0, 0, 1, 1, 8'h40, "");
        cyc(1, 3, 0, 8'h40, 0, 0, 0, "R8");
        // R8: same-cycle miss and local access on one address.
        cyc(1, 3, 0, 8'h64, 1, 2, 8'h64, "");
        cyc(1, 3, 0, 8'h64, 0, 0, 0, "R8");
        // R5/R4: saturate the ring and push until the queue fills.
        for (int k = 0; k < 7; k++) cyc(1, 0, 1, 8'h80 + k, 1, 3, 8'h90 + k, "");
        // R3/R4: returning requests free the slot for queued ones.
        for (int k = 0; k < 3; k++) cyc(1, ME, 2, 8'hA0 + k, 0, 0, 0, "");
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 0, 0, "");
        // Mixed traffic over a small address range.
        for (int k = 0; k < 600; k++) begin
            cyc(($urandom % 4) != 0, $urandom % 8, $urandom % 4, $urandom % 16,
                ($urandom % 3) == 0, $urandom % 4, $urandom % 16, "");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule